// File: doc/BRIEF.md
# Serial-to-Register Access Bridge

This block lets an external host reach an on-chip register space through a four-wire serial link. The host runs SPI mode 0: clock idle low, bits sampled on the rising clock edge, eight-bit units with the most significant bit first. Each access is framed by an active-low select. The first byte is a command byte that selects a block, a subblock and the direction. The second byte names a register. A write carries the 32-bit value next. A read carries two padding bytes, and then the bridge returns the 32-bit value. Multi-byte values travel most significant byte first.

The serial inputs are asynchronous to the system clock. They are resampled through a synchronizer chain and their edges are detected in the system clock domain, so the serial clock must be several system clocks slower than the system clock. On the chip side the bridge drives a plain parallel register port. The address is the concatenation of block, subblock and register number. There is a one-cycle write strobe with write data and a one-cycle read strobe. The register port returns read data in the same cycle as the read strobe.

Top module: `srb_bridge`

## Requirements
- R1: Bits on spi_mosi are sampled on rising spi_sclk edges while spi_cs_n is low and are assembled most significant bit first into bytes.
- R2: In the first byte of a frame, bits 7:5 are the block number, bit 4 is the direction (1 = write, 0 = read) and bits 3:0 are the subblock. The second byte is the register number. reg_addr equals {block, subblock, register} (15 bits) whenever a strobe is raised.
- R3: In a write frame, bytes 3 to 6 form the data word, most significant byte first. Exactly one single-cycle reg_we pulse carrying that word follows completion of byte 6.
- R4: In a read frame, exactly one single-cycle reg_re pulse is raised after byte 3 (the first padding byte) completes. reg_rdata is captured in that same cycle.
- R5: In a read frame, bytes 5 to 8 on spi_miso carry the captured word, most significant bit first. Each bit is updated after a falling spi_sclk edge and is valid at the next rising edge.
- R6: While spi_cs_n is low, spi_miso_oe is 1. spi_miso is 0 during bytes 1 to 4 of a read and during a whole write frame.
- R7: While spi_cs_n is high, spi_miso_oe is 0 and spi_miso is 0.
- R8: Raising spi_cs_n before the last byte of a frame completes aborts it. No reg_we is issued, and no reg_re is issued unless byte 3 of a read has completed.
- R9: Bytes past the frame length raise no further strobes. spi_miso is 0 after the 32 read bits.
- R10: Each falling spi_cs_n starts a fresh frame, so back-to-back frames decode independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| reg_addr | output | 15 | Register address {block, subblock, register} |
| reg_wdata | output | 32 | Write data, valid with reg_we |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 32 | Read data, sampled in the reg_re cycle |

## Verification
A wrong byte or bit count shows up on the register port within one frame. The strobe lands on the wrong byte or is missing, and reg_addr or reg_wdata comes out rotated by whole bytes or single bits. A stale transmit register or a late arming of the output stage corrupts the first returned bit. Missing clearing on select shows up at the start of the next frame, either as a strobe after an aborted frame or as MISO still enabled after select rises. The bench therefore compares strobe counts, address, data and every returned bit on each frame, and it checks the idle MISO state on every clock while select is high.

// File: rtl/srb_pkg.sv
package srb_pkg;
   localparam int CMD_W = 8;
   typedef struct packed {
      logic [2:0] blk;
      logic       wr;
      logic [3:0] sub;
   } srb_cmd_t;
endpackage

// File: rtl/srb_sync.sv
module srb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic cs_n_i,
   input  logic mosi_i,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_act,
   output logic mosi_s
);
   localparam logic [2:0] RST_VAL = 3'b010;
   localparam int LAST = STAGES - 1;

   logic [2:0] stg [STAGES];
   logic       sclk_d;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= {sclk_i, cs_n_i, mosi_i};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= stg[LAST][2];
   end

   assign sclk_rise = stg[LAST][2] & ~sclk_d;
   assign sclk_fall = ~stg[LAST][2] & sclk_d;
   assign cs_act    = ~stg[LAST][1];
   assign mosi_s    = stg[LAST][0];
endmodule

// File: rtl/srb_shift.sv
module srb_shift #(
   parameter int UNIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_rise,
   input  logic              mosi_s,
   output logic              unit_vld,
   output logic [UNIT_W-1:0] unit_q
);
   localparam int CNT_W = $clog2(UNIT_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UNIT_W - 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [UNIT_W-2:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         sh       <= '0;
         unit_vld <= 1'b0;
         unit_q   <= '0;
      end else begin
         unit_vld <= 1'b0;
         if (!cs_act) begin
            bit_cnt <= '0;
         end else if (sclk_rise) begin
            sh <= {sh[UNIT_W-3:0], mosi_s};
            if (bit_cnt == CNT_LAST) begin
               bit_cnt  <= '0;
               unit_vld <= 1'b1;
               unit_q   <= {sh, mosi_s};
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/srb_ctrl.sv
module srb_ctrl
   import srb_pkg::*;
#(
   parameter int BLK_W  = 3,
   parameter int SUB_W  = 4,
   parameter int REG_W  = 8,
   parameter int DATA_W = 32,
   parameter int PAD_N  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cs_act,
   input  logic                         unit_vld,
   input  logic [CMD_W-1:0]             unit_q,
   output logic [BLK_W+SUB_W+REG_W-1:0] addr,
   output logic [DATA_W-1:0]            wdata,
   output logic                         we,
   output logic                         re,
   output logic                         tx_arm
);
   localparam int DB       = DATA_W / 8;
   localparam int WR_LAST  = 2 + DB - 1;
   localparam int RD_PAD0  = 2;
   localparam int RD_ARM   = 2 + PAD_N - 1;
   localparam int FRM_MAX  = 2 + PAD_N + DB;
   localparam int IDX_W    = $clog2(FRM_MAX + 1);

   logic [IDX_W-1:0]  idx;
   logic [CMD_W-1:0]  cmd_q;
   logic [REG_W-1:0]  reg_q;
   logic [DATA_W-1:0] data_sh;
   logic              is_wr;

   assign is_wr = cmd_q[SUB_W];
   assign addr  = {cmd_q[CMD_W-1 -: BLK_W], cmd_q[SUB_W-1:0], reg_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx     <= '0;
         cmd_q   <= '0;
         reg_q   <= '0;
         data_sh <= '0;
         wdata   <= '0;
         we      <= 1'b0;
         re      <= 1'b0;
         tx_arm  <= 1'b0;
      end else begin
         we <= 1'b0;
         re <= 1'b0;
         if (!cs_act) begin
            idx    <= '0;
            tx_arm <= 1'b0;
         end else if (unit_vld) begin
            if (idx != IDX_W'(FRM_MAX)) idx <= idx + 1'b1;
            if (idx == IDX_W'(0)) cmd_q <= unit_q;
            if (idx == IDX_W'(1)) reg_q <= unit_q[REG_W-1:0];
            if (is_wr && idx >= IDX_W'(2) && idx <= IDX_W'(WR_LAST)) begin
               data_sh <= {data_sh[DATA_W-9:0], unit_q};
               if (idx == IDX_W'(WR_LAST)) begin
                  wdata <= {data_sh[DATA_W-9:0], unit_q};
                  we    <= 1'b1;
               end
            end
            if (!is_wr && idx == IDX_W'(RD_PAD0)) re     <= 1'b1;
            if (!is_wr && idx == IDX_W'(RD_ARM))  tx_arm <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/srb_tx.sv
module srb_tx #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_fall,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              arm,
   output logic              miso,
   output logic              miso_oe
);
   logic [DATA_W-1:0] tx_sr;
   logic              miso_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr  <= '0;
         miso_q <= 1'b0;
      end else begin
         if (!cs_act) begin
            miso_q <= 1'b0;
            tx_sr  <= '0;
         end else if (load) begin
            tx_sr <= load_data;
         end else if (sclk_fall && arm) begin
            miso_q <= tx_sr[DATA_W-1];
            tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign miso    = miso_q & cs_act;
   assign miso_oe = cs_act;
endmodule

// File: rtl/srb_bridge.sv
module srb_bridge
   import srb_pkg::*;
#(
   parameter int BLK_W       = 3,
   parameter int SUB_W       = 4,
   parameter int REG_W       = 8,
   parameter int DATA_W      = 32,
   parameter int PAD_N       = 2,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = BLK_W + SUB_W + REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              reg_re,
   input  logic [DATA_W-1:0] reg_rdata
);
   if (BLK_W + 1 + SUB_W != CMD_W) begin : g_bad_cmd
      $error("command fields must fill one byte");
   end
   if (REG_W > CMD_W || REG_W < 1) begin : g_bad_reg
      $error("register number must fit one byte");
   end
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
      $error("data width must be whole bytes, at least two");
   end
   if (PAD_N < 1) begin : g_bad_pad
      $error("at least one padding byte is needed");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs two stages or more");
   end

   logic             sclk_rise;
   logic             sclk_fall;
   logic             cs_act;
   logic             mosi_s;
   logic             unit_vld;
   logic [CMD_W-1:0] unit_q;
   logic             tx_arm;

   srb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (spi_sclk),
      .cs_n_i    (spi_cs_n),
      .mosi_i    (spi_mosi),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .cs_act    (cs_act),
      .mosi_s    (mosi_s)
   );

   srb_shift #(.UNIT_W(CMD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .sclk_rise (sclk_rise),
      .mosi_s    (mosi_s),
      .unit_vld  (unit_vld),
      .unit_q    (unit_q)
   );

   srb_ctrl #(
      .BLK_W  (BLK_W),
      .SUB_W  (SUB_W),
      .REG_W  (REG_W),
      .DATA_W (DATA_W),
      .PAD_N  (PAD_N)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (cs_act),
      .unit_vld (unit_vld),
      .unit_q   (unit_q),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .we       (reg_we),
      .re       (reg_re),
      .tx_arm   (tx_arm)
   );

   srb_tx #(.DATA_W(DATA_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .sclk_fall (sclk_fall),
      .load      (reg_re),
      .load_data (reg_rdata),
      .arm       (tx_arm),
      .miso      (spi_miso),
      .miso_oe   (spi_miso_oe)
   );
endmodule

// File: rtl/srb_bridge_chk.sv
module srb_bridge_chk #(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_act,
   input logic              tx_arm,
   input logic              spi_miso,
   input logic              spi_miso_oe,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic              reg_re
);
   a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   a_r4_re_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);
   a_r2_no_mixed_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));
   a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we || reg_re) |-> $stable(reg_addr));
   a_r7_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> (!spi_miso_oe && !spi_miso));
   a_r6_low_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !tx_arm && !$past(tx_arm)) |-> !spi_miso);
   a_r8_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (!reg_we && !reg_re));
endmodule

bind srb_bridge srb_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_act      (cs_act),
   .tx_arm      (tx_arm),
   .spi_miso    (spi_miso),
   .spi_miso_oe (spi_miso_oe),
   .reg_addr    (reg_addr),
   .reg_we      (reg_we),
   .reg_re      (reg_re)
);

// File: tb/srb_bridge_tb.sv
module srb_bridge_tb;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sclk = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_mosi = 1'b0;
   logic        spi_miso;
   logic        spi_miso_oe;
   logic [14:0] reg_addr;
   logic [31:0] reg_wdata;
   logic        reg_we;
   logic        reg_re;
   logic [31:0] reg_rdata;

   always #5 clk = ~clk;

   srb_bridge u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_sclk    (spi_sclk),
      .spi_cs_n    (spi_cs_n),
      .spi_mosi    (spi_mosi),
      .spi_miso    (spi_miso),
      .spi_miso_oe (spi_miso_oe),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_we      (reg_we),
      .reg_re      (reg_re),
      .reg_rdata   (reg_rdata)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   function automatic logic [31:0] bg_val(input logic [14:0] a);
      return {a, 2'b01, ~a} ^ 32'h5A5A_C3C3;
   endfunction

   // behavioural register space: one written word plus computed background
   logic [14:0] mw_addr = '0;
   logic [31:0] mw_data = '0;
   bit          mw_ok = 1'b0;
   assign reg_rdata = (mw_ok && reg_addr == mw_addr) ? mw_data : bg_val(reg_addr);

   int          we_cnt = 0;
   int          re_cnt = 0;
   logic [14:0] we_addr, re_addr;
   logic [31:0] we_data;
   int          cs_hi = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_we) begin
            we_cnt++; we_addr = reg_addr; we_data = reg_wdata;
         end
         if (reg_re) begin
            re_cnt++; re_addr = reg_addr;
         end
         cs_hi = spi_cs_n ? cs_hi + 1 : 0;
         if (cs_hi > 5)
            chk(spi_miso_oe == 1'b0 && spi_miso == 1'b0, "R7 idle miso",
                {30'd0, spi_miso_oe, spi_miso}, 32'd0);
         if (!spi_cs_n && cs_hi == 0 && spi_sclk)
            chk(spi_miso_oe == 1'b1, "R6 oe while selected", {31'd0, spi_miso_oe}, 32'd1);
      end
   end

   always @(posedge clk) begin
      if (reg_we) begin
         mw_addr <= reg_addr; mw_data <= reg_wdata; mw_ok <= 1'b1;
      end
   end

   logic [7:0] txb [12];
   logic [7:0] rxb [12];

   task automatic frame(input int n);
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int b = 0; b < n; b++) begin
         for (int i = 7; i >= 0; i--) begin
            spi_mosi = txb[b][i];
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            rxb[b][i] = spi_miso;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
         end
      end
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      spi_mosi = 1'b0;
      repeat (4 * HALF) @(negedge clk);
   endtask

   function automatic logic [7:0] cmd_byte(input logic [2:0] blk, input logic wr,
                                           input logic [3:0] sub);
      return {blk, wr, sub};
   endfunction

   task automatic do_write(input logic [2:0] blk, input logic [3:0] sub,
                           input logic [7:0] rg, input logic [31:0] d,
                           input int n, input bit expect_we);
      int w0;
      w0 = we_cnt;
      txb[0] = cmd_byte(blk, 1'b1, sub); txb[1] = rg;
      txb[2] = d[31:24]; txb[3] = d[23:16]; txb[4] = d[15:8]; txb[5] = d[7:0];
      for (int k = 6; k < 12; k++) txb[k] = 8'hC5;
      frame(n);
      chk(we_cnt - w0 == (expect_we ? 1 : 0), "R3/R8/R9 write strobe count",
          32'(we_cnt - w0), expect_we ? 32'd1 : 32'd0);
      if (expect_we) begin
         chk(we_addr == {blk, sub, rg}, "R2 write address", {17'd0, we_addr},
             {17'd0, blk, sub, rg});
         chk(we_data == d, "R3 R1 write data", we_data, d);
      end
      for (int k = 0; k < n; k++)
         chk(rxb[k] == 8'h00, "R6 miso low in write", {24'd0, rxb[k]}, 32'd0);
   endtask

   task automatic do_read(input logic [2:0] blk, input logic [3:0] sub,
                          input logic [7:0] rg, input logic [31:0] exp,
                          input int n, input bit full);
      int r0, w0;
      logic [31:0] got;
      r0 = re_cnt; w0 = we_cnt;
      txb[0] = cmd_byte(blk, 1'b0, sub); txb[1] = rg;
      for (int k = 2; k < 12; k++) txb[k] = 8'h00;
      frame(n);
      chk(we_cnt == w0, "R4 no write in read", 32'(we_cnt - w0), 32'd0);
      chk(re_cnt - r0 == (n >= 3 ? 1 : 0), "R4/R8 read strobe count",
          32'(re_cnt - r0), n >= 3 ? 32'd1 : 32'd0);
      if (n >= 3)
         chk(re_addr == {blk, sub, rg}, "R2 read address", {17'd0, re_addr},
             {17'd0, blk, sub, rg});
      for (int k = 0; k < 4 && k < n; k++)
         chk(rxb[k] == 8'h00, "R6 miso low before data", {24'd0, rxb[k]}, 32'd0);
      if (full) begin
         got = {rxb[4], rxb[5], rxb[6], rxb[7]};
         chk(got == exp, "R5 read data on miso", got, exp);
         for (int k = 8; k < n; k++)
            chk(rxb[k] == 8'h00, "R9 miso low after data", {24'd0, rxb[k]}, 32'd0);
      end
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
         report();
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // reset state
      chk(spi_miso_oe == 1'b0 && reg_we == 1'b0 && reg_re == 1'b0, "R7 reset outputs",
          {29'd0, spi_miso_oe, reg_we, reg_re}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 R2 R3 basic write, then R5 read-back
      do_write(3'd2, 4'd5, 8'h3C, 32'hDEAD_BEEF, 6, 1'b1);
      do_read (3'd2, 4'd5, 8'h3C, 32'hDEAD_BEEF, 8, 1'b1);
      // corner field values, background data
      do_read (3'd7, 4'd15, 8'hFF, bg_val({3'd7, 4'd15, 8'hFF}), 8, 1'b1);
      do_read (3'd0, 4'd0, 8'h00, bg_val(15'd0), 8, 1'b1);
      // sparse data pattern and all-ones, back-to-back frames (R10)
      do_write(3'd0, 4'd0, 8'h00, 32'h0000_0001, 6, 1'b1);
      do_read (3'd0, 4'd0, 8'h00, 32'h0000_0001, 8, 1'b1);
      do_write(3'd5, 4'd10, 8'h81, 32'hFFFF_FFFF, 6, 1'b1);
      do_read (3'd5, 4'd10, 8'h81, 32'hFFFF_FFFF, 8, 1'b1);
      // R8 aborted write after five bytes: no strobe, memory unchanged
      do_write(3'd5, 4'd10, 8'h81, 32'h1234_5678, 5, 1'b0);
      do_read (3'd5, 4'd10, 8'h81, 32'hFFFF_FFFF, 8, 1'b1);
      // R8 aborted read after two bytes: no read strobe
      do_read (3'd1, 4'd2, 8'h44, 32'd0, 2, 1'b0);
      // R9 over-long write and read
      do_write(3'd6, 4'd3, 8'h5A, 32'hA1B2_C3D4, 9, 1'b1);
      do_read (3'd6, 4'd3, 8'h5A, 32'hA1B2_C3D4, 10, 1'b1);
      // R10 a frame after an abort decodes cleanly
      do_write(3'd4, 4'd9, 8'h10, 32'h8000_0000, 3, 1'b0);
      do_write(3'd4, 4'd9, 8'h10, 32'h8000_0000, 6, 1'b1);
      do_read (3'd4, 4'd9, 8'h10, 32'h8000_0000, 8, 1'b1);

      done = 1'b1;
      report();
   end
endmodule